// File: doc/BRIEF.md
# Line-Fill Cacheability and State Decision

This block sits beside a cache tag controller. For each bus transaction it decides whether a line arriving from the memory bus is allocated, which coherence state it enters, and whether that line is read-only. It also produces the cache-enable indication that goes back to the CPU. Two hints from the memory side arrive when the cacheability window closes: a read-only hint and a cacheable-enable hint. Two more arrive when the snoop window closes: a write-through select and a direct-to-modified hint. The block samples each group on the first qualifying strobe, combines it with the access type, and reports one registered fill decision per read or allocation linefill.

A read-only hint forces the Shared state and sets a per-tag read-only bit. That bit stays set until the line is refilled. The hint keeps the CPU from caching data, but code may still be cached. The hint also overrides the snoop-window hints. A write cycle carries the read-only hint for the allocation linefill that follows it, because the linefill's own hint is not used. In sector mode, two neighbouring lines share one read-only bit. A protocol-error pulse flags a sibling fill that would leave a read-only sector writable. A lookup port reads the bit array.

Top module: `fill_state_ctrl`

## Requirements
- R1: After reset, cpu_ken, rfo_req, fill_valid, fill_alloc, fill_ro and proto_err are 0, fill_state is 0 (invalid), and every read-only bit reads 0 on lk_ro.
- R2: mem_ro and mem_ken are sampled only on the first cycle in which kwin_end is high after cyc_start. Later kwin_end strobes and later changes of these inputs in the same transaction have no effect.
- R3: An allocating fill whose effective read-only hint is 1 reports fill_state 1 (Shared) with fill_ro 1 and sets the line's read-only bit, so lk_ro reads 1. An allocating fill without the hint writes the bit to 0, except in the R11 case.
- R4: cyc_data = 1 marks a data access and 0 marks a code access. For a data read with the read-only hint, cpu_ken is 0 whatever mem_ken is. For code, or without the hint, cpu_ken equals the sampled mem_ken. For write cycles cpu_ken is 0.
- R5: The sampled mem_ken alone decides allocation. When it is 0, fill_alloc is 0, fill_state is 0 (invalid), fill_ro is 0 and the read-only bit is unchanged.
- R6: When an allocating fill has no read-only hint, the state is chosen in this order: for an allocation linefill with mem_dtm high at swin_end, 3 (Modified); otherwise, mem_wt high gives 1 (Shared) and mem_wt low gives 2 (Exclusive). Read fills ignore mem_dtm.
- R7: When the read-only hint is active, mem_wt and mem_dtm at swin_end are ignored and the state is Shared.
- R8: A write cycle pulses rfo_req for one cycle after its window end when mem_ken is 1 and mem_ro is 0. With mem_ro active, it never pulses rfo_req.
- R9: An allocation linefill (cyc_alloc = 1) uses the read-only hint sampled at the window end of the preceding write cycle. Its own mem_ro is ignored, both for cpu_ken and for the fill state.
- R10: With sector_mode = 1, lines 2k and 2k+1 share one read-only bit. With sector_mode = 0, every line has its own bit.
- R11: In sector mode, proto_err pulses together with fill_valid when a fill without the read-only hint would put a line whose shared bit is set into Exclusive or Modified. The bit then stays set.
- R12: cpu_ken changes in the cycle after the first kwin_end. It then holds until the next cyc_start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_mode | input | 1 | 1: two lines share one read-only bit |
| cyc_start | input | 1 | Starts a transaction (accepted when idle) |
| cyc_write | input | 1 | Transaction is a CPU write |
| cyc_alloc | input | 1 | Transaction is the linefill of a write allocation |
| cyc_data | input | 1 | 1 data access, 0 code access |
| cyc_line | input | IDX_W | Line index of the transaction |
| kwin_end | input | 1 | Cacheability window end strobe |
| mem_ro | input | 1 | Read-only hint from memory side |
| mem_ken | input | 1 | Cacheable-enable hint from memory side |
| swin_end | input | 1 | Snoop window end strobe |
| mem_wt | input | 1 | 1 write-through, 0 write-back |
| mem_dtm | input | 1 | Direct-to-modified hint |
| cpu_ken | output | 1 | Cache-enable to the CPU |
| rfo_req | output | 1 | Read-for-ownership request pulse |
| fill_valid | output | 1 | One-cycle pulse: fill decision valid |
| fill_alloc | output | 1 | Line is allocated |
| fill_state | output | 2 | 0 invalid, 1 Shared, 2 Exclusive, 3 Modified |
| fill_ro | output | 1 | Fill carried the read-only hint |
| proto_err | output | 1 | Sector read-only violation pulse |
| lk_line | input | IDX_W | Lookup line index |
| lk_ro | output | 1 | Read-only bit of lk_line |

## Verification
The assertions assume a few things about the inputs. kwin_end comes before swin_end in each transaction, and cyc_write and cyc_alloc are never both set. An allocation linefill always follows a write, and sector_mode does not change while a transaction is open. The stimulus opens each transaction with a single cyc_start and raises kwin_end only after a variable delay. It sends each allocation linefill directly after a write, and it changes sector_mode only between transactions. After the first window end, the bench drives inverted hints and an extra kwin_end strobe. Any effect they had on cpu_ken or the fill would show at the ports.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_KWIN = 2'd1,
        PH_SWIN = 2'd2
    } phase_t;

endpackage

// File: rtl/fill_decide.sv
module fill_decide
    import fill_pkg::*;
(
    input  logic     is_write,
    input  logic     is_alloc,
    input  logic     is_data,
    input  logic     pend_ro,
    input  logic     mem_ro,
    input  logic     mem_ken,
    input  logic     ro_s,
    input  logic     ken_s,
    input  logic     mem_wt,
    input  logic     mem_dtm,
    input  logic     sector_mode,
    input  logic     stored_ro,
    output logic     ro_k,
    output logic     cpu_ken_k,
    output logic     rfo_k,
    output line_st_t st_s,
    output logic     fro_s,
    output logic     robit_s,
    output logic     perr_s,
    output logic     alloc_s
);

    // cacheability window part: live hints
    always_comb begin
        ro_k      = is_alloc ? pend_ro : mem_ro;
        cpu_ken_k = !is_write && mem_ken && !(is_data && ro_k);
        rfo_k     = is_write && mem_ken && !ro_k;
    end

    // snoop window part: sampled hints plus live state selects
    always_comb begin
        alloc_s = ken_s;
        fro_s   = ken_s && ro_s;
        if (!ken_s)
            st_s = LS_INV;
        else if (ro_s)
            st_s = LS_SHR;
        else if (is_alloc && mem_dtm)
            st_s = LS_MOD;
        else if (mem_wt)
            st_s = LS_SHR;
        else
            st_s = LS_EXC;
        perr_s  = ken_s && !ro_s && sector_mode && stored_ro &&
                  ((st_s == LS_EXC) || (st_s == LS_MOD));
        robit_s = fro_s || perr_s;
    end

endmodule

// File: rtl/fill_ro_array.sv
module fill_ro_array #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_mode,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_bit
);

    logic [LINES-1:0] bits_d, bits_q;
    logic [IDX_W-1:0] weff, reff, leff;

    function automatic logic [IDX_W-1:0] slot(input logic sm, input logic [IDX_W-1:0] i);
        logic [IDX_W-1:0] r;
        r = i;
        if (sm) r[0] = 1'b0;
        return r;
    endfunction

    always_comb begin
        weff   = slot(sector_mode, widx);
        reff   = slot(sector_mode, ridx);
        leff   = slot(sector_mode, lk_idx);
        rbit   = bits_q[reff];
        lk_bit = bits_q[leff];
    end

    for (genvar g = 0; g < LINES; g++) begin : g_bit
        assign bits_d[g] = (we && (weff == IDX_W'(g))) ? wbit : bits_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bits_q)); // R3

    AST_SECTOR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_mode && we) |=> (bits_q[weff] == $past(wbit))); // R10

endmodule

// File: rtl/fill_seq.sv
module fill_seq
    import fill_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_mode,
    input  logic             cyc_start,
    input  logic             cyc_write,
    input  logic             cyc_alloc,
    input  logic             cyc_data,
    input  logic [IDX_W-1:0] cyc_line,
    input  logic             kwin_end,
    input  logic             mem_ken,
    input  logic             swin_end,
    input  logic             ro_k,
    input  logic             cpu_ken_k,
    input  logic             rfo_k,
    input  line_st_t         st_s,
    input  logic             fro_s,
    input  logic             robit_s,
    input  logic             perr_s,
    input  logic             alloc_s,
    output logic             write_q,
    output logic             alloc_q,
    output logic             data_q,
    output logic [IDX_W-1:0] line_q,
    output logic             pend_ro_q,
    output logic             ro_q,
    output logic             ken_q,
    output logic             arr_we,
    output logic             arr_bit,
    output logic             cpu_ken,
    output logic             rfo_req,
    output logic             fill_valid,
    output logic             fill_alloc,
    output line_st_t         fill_state,
    output logic             fill_ro,
    output logic             proto_err
);

    typedef struct packed {
        phase_t           phase;
        logic             write;
        logic             alloc;
        logic             data;
        logic [IDX_W-1:0] line;
        logic             ro;
        logic             ken;
        logic             pend_ro;
        logic             cpu_ken;
        logic             rfo;
        logic             fvalid;
        logic             falloc;
        line_st_t         fstate;
        logic             fro;
        logic             perr;
    } seq_t;

    seq_t r_d, r_q;
    logic kfire, sfire;

    always_comb begin
        kfire    = (r_q.phase == PH_KWIN) && kwin_end;
        sfire    = (r_q.phase == PH_SWIN) && swin_end;
        r_d      = r_q;
        r_d.rfo    = 1'b0;
        r_d.fvalid = 1'b0;
        r_d.perr   = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (cyc_start) begin
                    r_d.phase   = PH_KWIN;
                    r_d.write   = cyc_write;
                    r_d.alloc   = cyc_alloc;
                    r_d.data    = cyc_data;
                    r_d.line    = cyc_line;
                    r_d.cpu_ken = 1'b0;
                end
            end
            PH_KWIN: begin
                if (kfire) begin
                    r_d.phase   = PH_SWIN;
                    r_d.ro      = ro_k;
                    r_d.ken     = mem_ken;
                    r_d.cpu_ken = cpu_ken_k;
                    r_d.rfo     = rfo_k;
                    if (r_q.write) r_d.pend_ro = ro_k;
                end
            end
            PH_SWIN: begin
                if (sfire) begin
                    r_d.phase = PH_IDLE;
                    if (!r_q.write) begin
                        r_d.fvalid = 1'b1;
                        r_d.falloc = alloc_s;
                        r_d.fstate = st_s;
                        r_d.fro    = fro_s;
                        r_d.perr   = perr_s;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
        arr_we  = sfire && !r_q.write && r_q.ken;
        arr_bit = robit_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign write_q    = r_q.write;
    assign alloc_q    = r_q.alloc;
    assign data_q     = r_q.data;
    assign line_q     = r_q.line;
    assign pend_ro_q  = r_q.pend_ro;
    assign ro_q       = r_q.ro;
    assign ken_q      = r_q.ken;
    assign cpu_ken    = r_q.cpu_ken;
    assign rfo_req    = r_q.rfo;
    assign fill_valid = r_q.fvalid;
    assign fill_alloc = r_q.falloc;
    assign fill_state = r_q.fstate;
    assign fill_ro    = r_q.fro;
    assign proto_err  = r_q.perr;

    AST_DATA_RO_NOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (kfire && r_q.data && ro_k) |=> !cpu_ken); // R4

    AST_NO_RFO_ON_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (kfire && ro_k) |=> !rfo_req); // R8

    AST_KEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase != PH_KWIN && !(r_q.phase == PH_IDLE && cyc_start)) |=> $stable(cpu_ken)); // R12

    AST_RO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ro) |-> (fill_state == LS_SHR)); // R3

    AST_NOALLOC_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_alloc) |-> (fill_state == LS_INV && !fill_ro)); // R5

    AST_PERR_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (sector_mode && fill_valid && !fill_ro)); // R11

    AST_RFO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rfo_req |-> r_q.write); // R8

endmodule

// File: rtl/fill_state_ctrl.sv
module fill_state_ctrl
    import fill_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_mode,
    input  logic             cyc_start,
    input  logic             cyc_write,
    input  logic             cyc_alloc,
    input  logic             cyc_data,
    input  logic [IDX_W-1:0] cyc_line,
    input  logic             kwin_end,
    input  logic             mem_ro,
    input  logic             mem_ken,
    input  logic             swin_end,
    input  logic             mem_wt,
    input  logic             mem_dtm,
    output logic             cpu_ken,
    output logic             rfo_req,
    output logic             fill_valid,
    output logic             fill_alloc,
    output logic [1:0]       fill_state,
    output logic             fill_ro,
    output logic             proto_err,
    input  logic [IDX_W-1:0] lk_line,
    output logic             lk_ro
);

    logic             write_q, alloc_q, data_q, pend_ro_q, ro_q, ken_q;
    logic [IDX_W-1:0] line_q;
    logic             ro_k, cpu_ken_k, rfo_k, fro_s, robit_s, perr_s, alloc_s;
    line_st_t         st_s, fstate;
    logic             arr_we, arr_bit, stored_ro;

    fill_decide u_decide (
        .is_write   (write_q),
        .is_alloc   (alloc_q),
        .is_data    (data_q),
        .pend_ro    (pend_ro_q),
        .mem_ro     (mem_ro),
        .mem_ken    (mem_ken),
        .ro_s       (ro_q),
        .ken_s      (ken_q),
        .mem_wt     (mem_wt),
        .mem_dtm    (mem_dtm),
        .sector_mode(sector_mode),
        .stored_ro  (stored_ro),
        .ro_k       (ro_k),
        .cpu_ken_k  (cpu_ken_k),
        .rfo_k      (rfo_k),
        .st_s       (st_s),
        .fro_s      (fro_s),
        .robit_s    (robit_s),
        .perr_s     (perr_s),
        .alloc_s    (alloc_s)
    );

    fill_seq #(.LINES(LINES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sector_mode(sector_mode),
        .cyc_start  (cyc_start),
        .cyc_write  (cyc_write),
        .cyc_alloc  (cyc_alloc),
        .cyc_data   (cyc_data),
        .cyc_line   (cyc_line),
        .kwin_end   (kwin_end),
        .mem_ken    (mem_ken),
        .swin_end   (swin_end),
        .ro_k       (ro_k),
        .cpu_ken_k  (cpu_ken_k),
        .rfo_k      (rfo_k),
        .st_s       (st_s),
        .fro_s      (fro_s),
        .robit_s    (robit_s),
        .perr_s     (perr_s),
        .alloc_s    (alloc_s),
        .write_q    (write_q),
        .alloc_q    (alloc_q),
        .data_q     (data_q),
        .line_q     (line_q),
        .pend_ro_q  (pend_ro_q),
        .ro_q       (ro_q),
        .ken_q      (ken_q),
        .arr_we     (arr_we),
        .arr_bit    (arr_bit),
        .cpu_ken    (cpu_ken),
        .rfo_req    (rfo_req),
        .fill_valid (fill_valid),
        .fill_alloc (fill_alloc),
        .fill_state (fstate),
        .fill_ro    (fill_ro),
        .proto_err  (proto_err)
    );

    fill_ro_array #(.LINES(LINES)) u_roarr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sector_mode(sector_mode),
        .we         (arr_we),
        .widx       (line_q),
        .wbit       (arr_bit),
        .ridx       (line_q),
        .rbit       (stored_ro),
        .lk_idx     (lk_line),
        .lk_bit     (lk_ro)
    );

    assign fill_state = fstate;

endmodule

// File: tb/fill_state_ctrl_test.sv
`timescale 1ns/1ps
module fill_state_ctrl_test;

    localparam int LINES = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sector_mode = 1'b0;
    logic       cyc_start = 1'b0, cyc_write = 1'b0, cyc_alloc = 1'b0, cyc_data = 1'b0;
    logic [3:0] cyc_line = '0;
    logic       kwin_end = 1'b0, mem_ro = 1'b0, mem_ken = 1'b0;
    logic       swin_end = 1'b0, mem_wt = 1'b0, mem_dtm = 1'b0;
    logic       cpu_ken, rfo_req, fill_valid, fill_alloc, fill_ro, proto_err, lk_ro;
    logic [1:0] fill_state;
    logic [3:0] lk_line = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mbits [LINES];
    bit pend = 0;

    always #4 clk = ~clk;

    fill_state_ctrl #(.LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .sector_mode(sector_mode),
        .cyc_start(cyc_start), .cyc_write(cyc_write), .cyc_alloc(cyc_alloc),
        .cyc_data(cyc_data), .cyc_line(cyc_line),
        .kwin_end(kwin_end), .mem_ro(mem_ro), .mem_ken(mem_ken),
        .swin_end(swin_end), .mem_wt(mem_wt), .mem_dtm(mem_dtm),
        .cpu_ken(cpu_ken), .rfo_req(rfo_req), .fill_valid(fill_valid),
        .fill_alloc(fill_alloc), .fill_state(fill_state), .fill_ro(fill_ro),
        .proto_err(proto_err), .lk_line(lk_line), .lk_ro(lk_ro)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int slot(input bit sm, input int i);
        return sm ? (i & ~1) : i;
    endfunction

    // wr: write cycle, al: allocation linefill, dat: data access
    task automatic txn(input bit wr, input bit al, input bit dat, input int line,
                       input bit ro, input bit ken, input bit wt, input bit dtm, input int kdly);
        bit ro_eff, st_ro, exp_perr, exp_bit;
        int exp_st, sib;
        ro_eff = al ? pend : ro;
        @(negedge clk);
        cyc_start = 1; cyc_write = wr; cyc_alloc = al; cyc_data = dat; cyc_line = 4'(line);
        @(negedge clk);
        cyc_start = 0; cyc_write = !wr; cyc_alloc = 0; cyc_data = !dat; cyc_line = 4'(line + 5);
        mem_ro = !ro; mem_ken = !ken;
        chk("R12", "cpu_ken cleared by start", cpu_ken, 0);
        repeat (kdly) @(negedge clk);
        kwin_end = 1; mem_ro = ro; mem_ken = ken;
        @(negedge clk);
        // second strobe with inverted hints must be ignored (R2)
        kwin_end = 1; mem_ro = !ro; mem_ken = !ken;
        chk("R4", "cpu_ken after window end", cpu_ken,
            (!wr && ken && !(dat && ro_eff)) ? 1 : 0);
        chk("R8", "rfo_req", rfo_req, (wr && ken && !ro_eff) ? 1 : 0);
        @(negedge clk);
        kwin_end = 0;
        chk("R2", "cpu_ken after late strobe", cpu_ken,
            (!wr && ken && !(dat && ro_eff)) ? 1 : 0);
        chk("R8", "rfo_req single pulse", rfo_req, 0);
        swin_end = 1; mem_wt = wt; mem_dtm = dtm;
        @(negedge clk);
        swin_end = 0; mem_wt = !wt; mem_dtm = !dtm;
        if (wr) begin
            pend = ro;
            chk("R9", "no fill report on write", fill_valid, 0);
        end else begin
            st_ro = mbits[slot(sector_mode, line)];
            if (!ken)             exp_st = 0;
            else if (ro_eff)      exp_st = 1;
            else if (al && dtm)   exp_st = 3;
            else if (wt)          exp_st = 1;
            else                  exp_st = 2;
            exp_perr = ken && !ro_eff && sector_mode && st_ro && (exp_st >= 2);
            chk("R5", "fill_valid", fill_valid, 1);
            chk("R5", "fill_alloc", fill_alloc, ken);
            chk(ken ? (ro_eff ? "R7" : "R6") : "R5", "fill_state", fill_state, exp_st);
            chk(al ? "R9" : "R3", "fill_ro", fill_ro, (ken && ro_eff) ? 1 : 0);
            chk("R11", "proto_err", proto_err, exp_perr);
            if (ken) begin
                exp_bit = ro_eff || exp_perr;
                mbits[slot(sector_mode, line)] = exp_bit;
            end
            lk_line = 4'(line);
            #1;
            chk("R3", "lk_ro own line", lk_ro, mbits[slot(sector_mode, line)]);
            sib = line ^ 1;
            lk_line = 4'(sib);
            #1;
            chk("R10", "lk_ro sibling line", lk_ro, mbits[slot(sector_mode, sib)]);
        end
        @(negedge clk);
        chk("R12", "cpu_ken held after fill", cpu_ken,
            (!wr && ken && !(dat && ro_eff)) ? 1 : 0);
        chk("R5", "fill_valid one pulse", fill_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) mbits[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "cpu_ken", cpu_ken, 0);
        chk("R1", "rfo_req", rfo_req, 0);
        chk("R1", "fill_valid", fill_valid, 0);
        chk("R1", "fill_alloc", fill_alloc, 0);
        chk("R1", "fill_state", fill_state, 0);
        chk("R1", "fill_ro", fill_ro, 0);
        chk("R1", "proto_err", proto_err, 0);
        for (int i = 0; i < LINES; i++) begin
            lk_line = 4'(i);
            #1;
            chk("R1", "lk_ro", lk_ro, 0);
        end

        // directed: sector sharing and protocol error (R10, R11)
        sector_mode = 1;
        txn(0, 0, 1, 4, 1, 1, 0, 0, 1);
        lk_line = 4'd5; #1;
        chk("R10", "sector sibling sees ro", lk_ro, 1);
        txn(0, 0, 1, 5, 0, 1, 0, 0, 0);
        lk_line = 4'd4; #1;
        chk("R11", "bit kept after violation", lk_ro, 1);
        sector_mode = 0;
        txn(0, 0, 0, 6, 1, 1, 0, 0, 2);
        lk_line = 4'd7; #1;
        chk("R10", "no sharing outside sector mode", lk_ro, 0);
        // directed: write with ro, then allocation linefill (R8, R9)
        txn(1, 0, 1, 9, 1, 1, 0, 1, 0);
        txn(0, 1, 1, 9, 0, 1, 0, 1, 1);
        txn(1, 0, 1, 10, 0, 1, 1, 1, 0);
        txn(0, 1, 0, 10, 1, 1, 0, 1, 0);

        // near-exhaustive sweep
        for (int sm = 0; sm < 2; sm++) begin
            sector_mode = sm[0];
            for (int v = 0; v < 64; v++) begin
                int line;
                line = (v * 3 + sm) % LINES;
                if (v[5]) begin
                    txn(1, 0, 1, line, v[1], 1, v[3], v[4], v % 3);
                    txn(0, 1, v[0], line, !v[1], v[2], v[3], v[4], (v + 1) % 3);
                end else begin
                    txn(0, 0, v[0], line, v[1], v[2], v[3], v[4], v % 3);
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule